// File: doc/BRIEF.md
# Biphase-Mark Line Receiver with Self-Calibrating Lock

This block takes a biphase-mark coded serial line and recovers the data bits and a cell-rate clock from it. The line is sampled by a system clock that runs much faster than the cell rate, and the cell rate does not need to be known in advance. The block counts system clocks between line transitions. The shortest count seen so far serves as the half-cell length, and each new count is judged against it.

Before lock, the block only measures. It declares lock once the interval history shows that a half-cell interval has occurred. After lock, every transition is classified as a half or a whole cell. A whole cell ends a cell holding a 0. Two half cells in a row end a cell holding a 1. At each cell end, the recovered clock goes high for one half-cell length and the decoded bit is presented. The output therefore trails the line by one full cell, which is two half cells.

Top module: `bmark_rx`

## Requirements
- R1: After a synchronous active-high reset, `locked`, `cell_clk` and `bit_out` are all 0.
- R2: A transition is registered at the first rising clock edge at which `line_in` differs from its value at the previous edge. The first transition after reset only starts the interval count. The interval from the first to the second transition is the first measurement, and lock cannot be declared on that measurement.
- R3: Lock via a short interval. At a later transition, let I be the interval ending there and M the smallest interval measured before it. `locked` goes to 1 at the edge where 4·I < 3·M. M then becomes I.
- R4: Lock via a long interval. If, while unlocked, an interval satisfies 2·I ≥ 3·M, `locked` goes to 1 at that edge. The transition is taken as the end of a cell holding 0, so `bit_out` becomes 0 and `cell_clk` rises.
- R5: Once locked, an interval with 2·I < 3·M is a half cell, and any other interval is a whole cell. A whole cell ends a cell and decodes to 0. A second consecutive half cell ends a cell and decodes to 1. A first half cell marks mid-cell.
- R6: At each cell-ending transition, `cell_clk` goes to 1 for M clock cycles, where M is the updated minimum, and then returns to 0. A mid-cell transition forces it to 0. It stays 0 while unlocked.
- R7: `bit_out` changes only at a cell-ending transition, in the same cycle as `cell_clk` rises. It then holds until the next cell end.
- R8: Interval counting saturates at 255. A transition after a long idle line is therefore a whole cell and never a half cell.
- R9: Once set, `locked` stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| line_in | input | 1 | Biphase-mark coded serial line |
| locked | output | 1 | Receiver has calibrated to the cell rate |
| cell_clk | output | 1 | Recovered clock, high during first half of each output cell |
| bit_out | output | 1 | Decoded data bit, valid from each rise of `cell_clk` |

## Verification
Two events can fall on the same clock edge. The transition that declares lock can also be the one that ends a cell and starts the recovered clock. In the same way, a transition that arrives after a saturated idle count must both close a cell and restart the clock window. The bench provokes the first case with a stream that opens with 1 bits, so lock comes through a long interval at a cell boundary. It provokes the second by holding the line for 300 cycles before a single toggle. In both cases, a behavioural reference of intervals and minimum, run alongside the design, supplies the expected values of `locked`, `cell_clk` and `bit_out` for every cycle.

// File: rtl/bmark_rx.sv
module bmark_rx #(
  parameter int CW = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic line_in,
  output logic locked,
  output logic cell_clk,
  output logic bit_out
);

  localparam int WW = CW + 2;
  localparam logic [CW-1:0] TOP = '1;

  logic          line_q;
  logic          started;
  logic          cal;
  logic          pend;
  logic [CW-1:0] gap;
  logic [CW-1:0] floor_q;
  logic [CW-1:0] phase;

  wire edge_hit = line_in ^ line_q;

  wire [WW-1:0] g  = {2'b00, gap};
  wire [WW-1:0] f  = {2'b00, floor_q};
  wire [WW-1:0] g2 = g << 1;
  wire [WW-1:0] g4 = g << 2;
  wire [WW-1:0] f3 = f + (f << 1);

  wire short_gap = g4 < f3;
  wire long_gap  = g2 >= f3;
  wire half_gap  = g2 < f3;

  wire [CW-1:0] floor_nx = (gap < floor_q) ? gap : floor_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q   <= line_in;
      started  <= 1'b0;
      cal      <= 1'b0;
      pend     <= 1'b0;
      gap      <= '0;
      floor_q  <= TOP;
      phase    <= '0;
      locked   <= 1'b0;
      cell_clk <= 1'b0;
      bit_out  <= 1'b0;
    end else begin
      line_q <= line_in;

      if (edge_hit)
        gap <= {{(CW-1){1'b0}}, 1'b1};
      else if (gap != TOP)
        gap <= gap + 1'b1;

      if (phase != TOP)
        phase <= phase + 1'b1;

      if (phase >= floor_q)
        cell_clk <= 1'b0;

      if (edge_hit) begin
        started <= 1'b1;
        if (started) begin
          cal     <= 1'b1;
          floor_q <= floor_nx;
          if (!locked) begin
            if (cal && short_gap) begin
              locked <= 1'b1;
              pend   <= 1'b1;
            end else if (cal && long_gap) begin
              locked   <= 1'b1;
              pend     <= 1'b0;
              cell_clk <= 1'b1;
              phase    <= {{(CW-1){1'b0}}, 1'b1};
              bit_out  <= 1'b0;
            end
          end else if (half_gap) begin
            if (pend) begin
              pend     <= 1'b0;
              cell_clk <= 1'b1;
              phase    <= {{(CW-1){1'b0}}, 1'b1};
              bit_out  <= 1'b1;
            end else begin
              pend     <= 1'b1;
              cell_clk <= 1'b0;
            end
          end else begin
            pend     <= 1'b0;
            cell_clk <= 1'b1;
            phase    <= {{(CW-1){1'b0}}, 1'b1};
            bit_out  <= 1'b0;
          end
        end
      end
    end
  end

endmodule

// File: rtl/bmark_rx_chk.sv
module bmark_rx_chk (
  input logic clk,
  input logic rst,
  input logic line_in,
  input logic locked,
  input logic cell_clk,
  input logic bit_out
);

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!locked && !cell_clk && !bit_out));

  // R9
  lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
    locked |=> locked);

  // R3
  lock_on_edge_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> ($past(line_in) != $past(line_in, 2)));

  // R6
  clk_needs_lock_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cell_clk) |-> locked);

  // R7
  data_with_clk_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(bit_out) |-> cell_clk);

endmodule

bind bmark_rx bmark_rx_chk u_chk (
  .clk(clk), .rst(rst), .line_in(line_in),
  .locked(locked), .cell_clk(cell_clk), .bit_out(bit_out)
);

// File: tb/bmark_rx_tb.sv
`timescale 1ns/1ps
module bmark_rx_tb;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic line_in = 1'b0;
  logic locked, cell_clk, bit_out;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bmark_rx u_dut (
    .clk(clk), .rst(rst), .line_in(line_in),
    .locked(locked), .cell_clk(cell_clk), .bit_out(bit_out)
  );

  // behavioural reference state
  int  age, m_min, rleft;
  bit  m_prev, m_seen, m_cal, m_lock, m_pend, e_dout;

  task automatic chk(bit ok, string tag, int act, int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    age = 0; m_min = 255; rleft = 0;
    m_prev = 1'b0; m_seen = 1'b0; m_cal = 1'b0;
    m_lock = 1'b0; m_pend = 1'b0; e_dout = 1'b0;
  endtask

  task automatic cell_end(bit b);
    e_dout = b;
    rleft  = m_min;
  endtask

  task automatic model_step(bit ln);
    bit edge_now;
    int iv, oldmin;
    bit cal_old;
    edge_now = (ln != m_prev);
    m_prev = ln;
    if (rleft > 0) rleft--;
    if (edge_now) begin
      iv = (age + 1 > 255) ? 255 : age + 1;
      age = 0;
      if (m_seen) begin
        oldmin  = m_min;
        cal_old = m_cal;
        m_cal   = 1'b1;
        if (iv < m_min) m_min = iv;
        if (!m_lock) begin
          if (cal_old && (4*iv < 3*oldmin)) begin
            m_lock = 1'b1; m_pend = 1'b1;
          end else if (cal_old && (2*iv >= 3*oldmin)) begin
            m_lock = 1'b1; m_pend = 1'b0; cell_end(1'b0);
          end
        end else if (2*iv < 3*oldmin) begin
          if (m_pend) begin m_pend = 1'b0; cell_end(1'b1); end
          else begin m_pend = 1'b1; rleft = 0; end
        end else begin
          m_pend = 1'b0; cell_end(1'b0);
        end
      end
      m_seen = 1'b1;
    end else if (age < 100000) begin
      age++;
    end
  endtask

  // one clock: compare outputs of last edge, then drive next line value
  task automatic tick(bit v);
    @(negedge clk);
    chk(locked == m_lock, "R3 R4 R9 lock", locked, m_lock);
    chk(cell_clk == (rleft > 0), "R6 cell_clk", cell_clk, (rleft > 0));
    chk(bit_out == e_dout, "R5 R7 R8 bit_out", bit_out, e_dout);
    line_in = v;
    model_step(v);
  endtask

  task automatic send_cell(int h, bit b);
    tick(!line_in);
    for (int i = 0; i < h-1; i++) tick(line_in);
    if (b) tick(!line_in); else tick(line_in);
    for (int i = 0; i < h-1; i++) tick(line_in);
  endtask

  task automatic peek();
    @(posedge clk);
    #2;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    line_in = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model_reset();
    model_step(1'b0);
  endtask

  initial begin
    logic [15:0] lfsr;
    bit fresh;

    model_reset();
    do_reset();
    peek();
    chk(!locked && !cell_clk && !bit_out, "R1 reset state",
        {locked, cell_clk, bit_out}, 0);

    // Scenario A: opens with 0 bits, lock via short interval (R2, R3)
    send_cell(4, 1'b0);
    send_cell(4, 1'b0);
    peek();
    chk(locked == 1'b0, "R2 no lock on first measurement", locked, 0);
    send_cell(4, 1'b1);
    peek();
    chk(locked == 1'b1, "R3 lock after half cell", locked, 1);
    begin
      bit seq [18] = '{0,1,1,0,0,1,0,1,1,1,0,0,1,0,1,0,0,1};
      foreach (seq[i]) send_cell(4, seq[i]);
    end

    // dead line, then one toggle (R8)
    for (int i = 0; i < 300; i++) tick(line_in);
    tick(!line_in);
    peek();
    chk(locked && cell_clk && !bit_out, "R8 saturated interval is whole cell",
        {locked, cell_clk, bit_out}, 3'b110);
    for (int i = 0; i < 7; i++) tick(line_in);
    begin
      bit seq2 [6] = '{1,0,1,1,0,0};
      foreach (seq2[i]) send_cell(4, seq2[i]);
    end

    // Scenario B: reset clears lock (R9), stream opens with 1s (R4)
    do_reset();
    peek();
    chk(locked == 1'b0, "R9 reset clears lock", locked, 0);
    send_cell(5, 1'b1);
    send_cell(5, 1'b1);
    send_cell(5, 1'b0);
    peek();
    chk(locked == 1'b0, "R4 no lock on equal half cells", locked, 0);
    send_cell(5, 1'b1);
    peek();
    chk(locked == 1'b1, "R4 lock after long interval", locked, 1);
    begin
      bit seq3 [12] = '{0,0,1,1,0,1,0,0,0,1,1,0};
      foreach (seq3[i]) send_cell(5, seq3[i]);
    end

    // Scenario C: pseudo-random data at a short half-cell length (R5)
    do_reset();
    lfsr = 16'hACE1;
    fresh = 1'b1;
    send_cell(3, 1'b0);
    send_cell(3, 1'b0);
    for (int i = 0; i < 60; i++) begin
      send_cell(3, lfsr[0]);
      lfsr = {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};
    end
    tick(line_in);
    fresh = 1'b0;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

endmodule